// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block receives configuration words over a write-only three-wire serial link: a data line, a serial clock and an active-low strobe that frames each transfer. While the strobe is low, every rising serial clock edge shifts one bit into a 16-bit window, most significant bit first. Only the newest 16 bits survive, so a sender may clock in any number of bits and the leading excess simply falls out. When the strobe returns high, the low four bits of the window are compared with a fixed device address. On a match, a two-bit subaddress selects one of three bus-side registers, which takes the upper ten bits as its new contents.

The bus side runs only on the serial wires and stays writable while the core is powered down. A core-side copy of the registers, clocked by the master clock, feeds the decoded control fields. A write is announced to the core through a toggle that is synchronised across clock domains. The copy is taken only while the power enable is high. A write made during power-down is held as pending and applied on the first core clock edge after power returns. Two bits of the power-level register control a general-purpose three-state pin, presented as an enable and a value.

Top module: `cfg_serial_slave`

## Requirements
- R1: After a synchronous reset all decoded outputs, including the pin enable and value, are zero, and all three bus-side registers are cleared.
- R2: A bit is shifted in only on a rising serial clock edge while the strobe is low, most significant bit first. Serial clock edges while the strobe is high leave the shift window unchanged, and the window keeps its contents from one transfer to the next.
- R3: Only the last 16 bits shifted in are decoded. A transfer of more than 16 bits loads exactly as its final 16 bits would.
- R4: A register is written only when frame bits 3..0 equal 1010. Any other address leaves every output unchanged.
- R5: Subaddress 00 (frame bits 5..4) writes the kick level from frame bits 15..10, the limiter select from bits 9..8, direct control from bit 7 and test mode from bit 6.
- R6: Subaddress 01 writes the home level from bits 15..10, the temperature-coefficient select from bits 9..8, the sensor-gain range from bit 7 and the slope range from bit 6.
- R7: Subaddress 11 writes the power level from bits 15..8, the pin-drive enable from bit 7 and the pin value from bit 6.
- R8: Subaddress 10 writes nothing.
- R9: The load happens on the rising edge of the strobe. With the power enable high, the outputs take the new value at the third rising core clock edge after that strobe edge, and not before.
- R10: While the power enable is low, the outputs hold. Writes made meanwhile are kept, and all of them appear at the first core clock edge at which the power enable is high again.
- R11: The pin enable output equals the stored enable bit, and the pin value output equals the stored value bit.
- R12: A write to one subaddress leaves the fields of the other two unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core master clock |
| rst | input | 1 | Reset, active high (synchronous for the core, also clears the bus side) |
| pwr_up | input | 1 | Core power enable; low means powered down |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data |
| ser_stb_n | input | 1 | Transfer strobe, active low |
| kick_lvl | output | 6 | Kick level |
| lim_sel | output | 2 | Limiter select |
| direct_ctl | output | 1 | Direct-control flag |
| test_mode | output | 1 | Test-mode flag |
| home_lvl | output | 6 | Home level |
| tc_sel | output | 2 | Temperature-coefficient select |
| rng_gain | output | 1 | Sensor-gain range bit |
| rng_slope | output | 1 | Slope range bit |
| pwr_lvl | output | 8 | Burst power level |
| gp_oe | output | 1 | General-purpose pin drive enable |
| gp_o | output | 1 | General-purpose pin value |

## Verification
The bench aims at the strobe-edge latency. A missing or extra synchroniser stage would move the output change off the third core clock edge. It sends serial clocks with the strobe high and then a short 8-bit transfer whose decoded value depends on the bits left from the previous frame. A shifter that counted clocks, ignored the strobe or cleared itself between transfers would load a different power level. Over-long frames, the unused subaddress and a wrong device address are sent to catch decoders that fail to discard leading bits or that write a stray register. Two writes made during power-down catch a core that updates early, or that drops or reorders a write deferred until power returns.

// File: rtl/cfg_ss_pkg.sv
package cfg_ss_pkg;
  localparam int DATA_W    = 10;
  localparam int SUB_W     = 2;
  localparam int ADDR_W    = 4;
  localparam int FRAME_W   = DATA_W + SUB_W + ADDR_W;
  localparam int NUM_SLOTS = 1 << SUB_W;
  localparam logic [ADDR_W-1:0]    DEV_ADDR  = 4'b1010;
  // slot 2 is not backed by a register
  localparam logic [NUM_SLOTS-1:0] SLOT_USED = 4'b1011;
  localparam int SLOT_KICK = 0;
  localparam int SLOT_HOME = 1;
  localparam int SLOT_PWR  = 3;
endpackage

// File: rtl/cfg_ss_shift.sv
module cfg_ss_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               ser_clk,
  input  logic               ser_stb_n,
  input  logic               ser_dat,
  output logic [FRAME_W-1:0] frame
);
  // window of the newest FRAME_W bits, MSB first
  always_ff @(posedge ser_clk) begin
    if (!ser_stb_n) frame <= {frame[FRAME_W-2:0], ser_dat};
  end
endmodule

// File: rtl/cfg_ss_bank.sv
module cfg_ss_bank #(
  parameter int DATA_W = 10,
  parameter int SUB_W  = 2,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 4'b1010,
  parameter logic [(1<<SUB_W)-1:0] SLOT_USED = 4'b1011,
  localparam int NUM_SLOTS = 1 << SUB_W,
  localparam int FRAME_W   = DATA_W + SUB_W + ADDR_W,
  localparam int BANK_W    = NUM_SLOTS * DATA_W
) (
  input  logic               rst,
  input  logic               ser_stb_n,
  input  logic [FRAME_W-1:0] frame,
  output logic [BANK_W-1:0]  bank,
  output logic               load_tgl
);
  logic [ADDR_W-1:0] f_addr;
  logic [SUB_W-1:0]  f_sub;
  logic [DATA_W-1:0] f_data;
  logic              addr_hit;
  logic              accept;

  assign f_addr   = frame[ADDR_W-1:0];
  assign f_sub    = frame[ADDR_W +: SUB_W];
  assign f_data   = frame[FRAME_W-1 -: DATA_W];
  assign addr_hit = (f_addr == DEV_ADDR);
  assign accept   = addr_hit && SLOT_USED[f_sub];

  // the strobe's rising edge is the load pulse for the bus side
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (SLOT_USED[s]) begin : g_reg
      always_ff @(posedge ser_stb_n or posedge rst) begin
        if (rst) bank[s*DATA_W +: DATA_W] <= '0;
        else if (addr_hit && f_sub == SUB_W'(s)) bank[s*DATA_W +: DATA_W] <= f_data;
      end
    end else begin : g_none
      assign bank[s*DATA_W +: DATA_W] = '0;
    end
  end

  always_ff @(posedge ser_stb_n or posedge rst) begin
    if (rst) load_tgl <= 1'b0;
    else if (accept) load_tgl <= ~load_tgl;
  end
endmodule

// File: rtl/cfg_ss_xfer.sv
module cfg_ss_xfer #(
  parameter int BANK_W      = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_up,
  input  logic              load_tgl,
  input  logic [BANK_W-1:0] bank_in,
  output logic [BANK_W-1:0] core_bank,
  output logic              go,
  output logic              pend
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_q;
  logic                   pulse;

  assign pulse = sync_q[SYNC_STAGES-1] ^ seen_q;
  assign go    = pwr_up && (pend || pulse);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      seen_q    <= 1'b0;
      pend      <= 1'b0;
      core_bank <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], load_tgl};
      seen_q <= sync_q[SYNC_STAGES-1];
      pend   <= (pend || pulse) && !pwr_up;
      if (go) core_bank <= bank_in;
    end
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfg_ss_pkg::*;
#(
  parameter int DATA_W      = cfg_ss_pkg::DATA_W,
  parameter int SUB_W       = cfg_ss_pkg::SUB_W,
  parameter int ADDR_W      = cfg_ss_pkg::ADDR_W,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W    = DATA_W + SUB_W + ADDR_W,
  localparam int BANK_W     = (1 << SUB_W) * DATA_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_up,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       ser_stb_n,
  output logic [5:0] kick_lvl,
  output logic [1:0] lim_sel,
  output logic       direct_ctl,
  output logic       test_mode,
  output logic [5:0] home_lvl,
  output logic [1:0] tc_sel,
  output logic       rng_gain,
  output logic       rng_slope,
  output logic [7:0] pwr_lvl,
  output logic       gp_oe,
  output logic       gp_o
);
  logic [FRAME_W-1:0] frame;
  logic [BANK_W-1:0]  bank;
  logic [BANK_W-1:0]  core_bank;
  logic               load_tgl;
  logic               xfer_go;
  logic               xfer_pend;
  logic [DATA_W-1:0]  w_kick, w_home, w_pwr;

  cfg_ss_shift #(.FRAME_W(FRAME_W)) u_shift (
    .ser_clk(ser_clk), .ser_stb_n(ser_stb_n), .ser_dat(ser_dat), .frame(frame)
  );

  cfg_ss_bank #(
    .DATA_W(DATA_W), .SUB_W(SUB_W), .ADDR_W(ADDR_W),
    .DEV_ADDR(DEV_ADDR), .SLOT_USED(SLOT_USED)
  ) u_bank (
    .rst(rst), .ser_stb_n(ser_stb_n), .frame(frame), .bank(bank), .load_tgl(load_tgl)
  );

  cfg_ss_xfer #(.BANK_W(BANK_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .clk(clk), .rst(rst), .pwr_up(pwr_up), .load_tgl(load_tgl), .bank_in(bank),
    .core_bank(core_bank), .go(xfer_go), .pend(xfer_pend)
  );

  assign w_kick = core_bank[SLOT_KICK*DATA_W +: DATA_W];
  assign w_home = core_bank[SLOT_HOME*DATA_W +: DATA_W];
  assign w_pwr  = core_bank[SLOT_PWR*DATA_W  +: DATA_W];

  assign kick_lvl   = w_kick[9:4];
  assign lim_sel    = w_kick[3:2];
  assign direct_ctl = w_kick[1];
  assign test_mode  = w_kick[0];
  assign home_lvl   = w_home[9:4];
  assign tc_sel     = w_home[3:2];
  assign rng_gain   = w_home[1];
  assign rng_slope  = w_home[0];
  assign pwr_lvl    = w_pwr[9:2];
  assign gp_oe      = w_pwr[1];
  assign gp_o       = w_pwr[0];
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int BANK_W = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_up,
  input logic              xfer_go,
  input logic              xfer_pend,
  input logic [BANK_W-1:0] core_bank,
  input logic              gp_oe
);
  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> core_bank == '0); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!xfer_go && !rst) |=> $stable(core_bank)); // R9
  AST_HOLD_PWRDN: assert property (@(posedge clk) disable iff (rst)
    (!pwr_up && !rst) |=> $stable(core_bank)); // R10
  AST_PEND_ONLY_DOWN: assert property (@(posedge clk) disable iff (rst)
    xfer_pend |-> !$past(pwr_up)); // R10
  AST_GP_OE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(gp_oe) |-> $past(xfer_go)); // R11
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst(rst), .pwr_up(pwr_up), .xfer_go(xfer_go),
  .xfer_pend(xfer_pend), .core_bank(core_bank), .gp_oe(gp_oe)
);

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_up = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic ser_stb_n = 1'b1;
  logic [5:0] kick_lvl, home_lvl;
  logic [1:0] lim_sel, tc_sel;
  logic direct_ctl, test_mode, rng_gain, rng_slope, gp_oe, gp_o;
  logic [7:0] pwr_lvl;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit run = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  bit [15:0] m_shift = '0;
  bit [9:0]  m_bus  [4];
  bit [9:0]  m_core [4];
  int        m_q [$];
  bit        m_pend = 1'b0;

  always #10 clk = ~clk;

  cfg_serial_slave u_dut (
    .clk(clk), .rst(rst), .pwr_up(pwr_up), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_stb_n(ser_stb_n), .kick_lvl(kick_lvl), .lim_sel(lim_sel),
    .direct_ctl(direct_ctl), .test_mode(test_mode), .home_lvl(home_lvl),
    .tc_sel(tc_sel), .rng_gain(rng_gain), .rng_slope(rng_slope),
    .pwr_lvl(pwr_lvl), .gp_oe(gp_oe), .gp_o(gp_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit [39:0] got_vec();
    return {kick_lvl, lim_sel, direct_ctl, test_mode, home_lvl, tc_sel,
            rng_gain, rng_slope, pwr_lvl, gp_oe, gp_o, 4'b0};
  endfunction

  function automatic bit [39:0] exp_vec();
    return {m_core[0], m_core[1], m_core[3], 4'b0};
  endfunction

  // model core side: fire the third rising edge after the strobe edge
  always @(posedge clk) begin
    if (rst) begin
      foreach (m_core[s]) m_core[s] = '0;
      m_pend = 1'b0;
      m_q.delete();
    end else begin
      for (int k = 0; k < m_q.size(); k++) m_q[k] = m_q[k] - 1;
      while (m_q.size() > 0 && m_q[0] <= 0) begin
        void'(m_q.pop_front());
        m_pend = 1'b1;
      end
      if (m_pend && pwr_up) begin
        m_core = m_bus;
        m_pend = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (run) chk(cur_req, "outputs", int'(got_vec() >> 4), int'(exp_vec() >> 4));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(input bit [31:0] v, input int n);
    @(negedge clk) ser_stb_n = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      @(negedge clk) ser_clk = 1'b1;
      m_shift = {m_shift[14:0], v[i]};
      @(negedge clk) ser_clk = 1'b0;
    end
    @(negedge clk) ser_stb_n = 1'b1;
    if (m_shift[3:0] == 4'b1010 && m_shift[5:4] != 2'b10) begin
      m_bus[m_shift[5:4]] = m_shift[15:6];
      m_q.push_back(3);
    end
  endtask

  task automatic idle_clocks(input bit d, input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = d;
      @(negedge clk) ser_clk = 1'b1;
      @(negedge clk) ser_clk = 1'b0;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit [31:0] frm(input bit [9:0] d, input bit [1:0] sub, input bit [3:0] a);
    return {16'b0, d, sub, a};
  endfunction

  initial begin
    foreach (m_bus[s]) m_bus[s] = '0;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    chk("R1", "reset pwr_lvl", int'(pwr_lvl), 0);
    chk("R1", "reset gp_oe", int'(gp_oe), 0);
    chk("R1", "reset kick", int'(kick_lvl), 0);
    run = 1'b1;
    pwr_up = 1'b1;

    cur_req = "R5";
    send(frm(10'b101101_10_1_0, 2'b00, 4'b1010), 16);
    wait_clk(5);
    chk("R5", "kick", int'(kick_lvl), 45);
    chk("R5", "lim", int'(lim_sel), 2);
    chk("R5", "dctl", int'(direct_ctl), 1);
    chk("R5", "test", int'(test_mode), 0);

    cur_req = "R6";
    send(frm(10'b011110_01_1_1, 2'b01, 4'b1010), 16);
    wait_clk(5);
    chk("R6", "home", int'(home_lvl), 30);
    chk("R6", "tc", int'(tc_sel), 1);
    chk("R6", "ranges", int'({rng_gain, rng_slope}), 3);
    chk("R12", "kick kept", int'(kick_lvl), 45);

    cur_req = "R7";
    send(frm(10'b11001010_1_1, 2'b11, 4'b1010), 16);
    wait_clk(5);
    chk("R7", "pwr", int'(pwr_lvl), 'hCA);
    chk("R11", "oe", int'(gp_oe), 1);
    chk("R11", "o", int'(gp_o), 1);
    chk("R12", "home kept", int'(home_lvl), 30);
    cur_req = "R11";
    send(frm(10'b00001111_1_0, 2'b11, 4'b1010), 16);
    wait_clk(5);
    chk("R11", "oe drive0", int'({gp_oe, gp_o}), 2);
    send(frm(10'b00001111_0_1, 2'b11, 4'b1010), 16);
    wait_clk(5);
    chk("R11", "oe off", int'(gp_oe), 0);

    cur_req = "R8";
    send(frm(10'h3FF, 2'b10, 4'b1010), 16);
    wait_clk(6);
    chk("R8", "pwr kept", int'(pwr_lvl), 'h0F);
    chk("R8", "kick kept", int'(kick_lvl), 45);

    cur_req = "R4";
    send(frm(10'h000, 2'b00, 4'b1011), 16);
    wait_clk(6);
    chk("R4", "kick kept", int'(kick_lvl), 45);

    cur_req = "R2";
    send(frm(10'b110011_01_1_0, 2'b00, 4'b1010), 16);
    wait_clk(5);
    chk("R2", "kick", int'(kick_lvl), 51);
    @(negedge clk) ser_stb_n = 1'b1;
    idle_clocks(1'b1, 5);
    send(32'b01_11_1010, 8);
    wait_clk(5);
    chk("R2", "pwr from window", int'(pwr_lvl), 'h8A);
    chk("R2", "pin bits", int'({gp_oe, gp_o}), 1);

    cur_req = "R3";
    send({8'hFF, 16'h0, frm(10'b000111_11_0_1, 2'b01, 4'b1010)} | 32'h00FF_0000, 24);
    wait_clk(5);
    chk("R3", "home", int'(home_lvl), 7);
    chk("R3", "tc", int'(tc_sel), 3);

    cur_req = "R10";
    @(negedge clk) pwr_up = 1'b0;
    send(frm(10'b01010101_0_0, 2'b11, 4'b1010), 16);
    wait_clk(8);
    chk("R10", "pwr held", int'(pwr_lvl), 'h8A);
    send(frm(10'b000001_00_0_0, 2'b00, 4'b1010), 16);
    wait_clk(8);
    chk("R10", "kick held", int'(kick_lvl), 51);
    @(negedge clk) pwr_up = 1'b1;
    wait_clk(1);
    chk("R10", "pwr applied", int'(pwr_lvl), 'h55);
    chk("R10", "kick applied", int'(kick_lvl), 1);

    cur_req = "R9";
    send(frm(10'b00110011_0_0, 2'b11, 4'b1010), 16);
    @(posedge clk); @(posedge clk); #1;
    chk("R9", "before edge3", int'(pwr_lvl), 'h55);
    @(posedge clk); #1;
    chk("R9", "at edge3", int'(pwr_lvl), 'h33);
    wait_clk(4);

    run = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule